// File: doc/BRIEF.md
# SD Card Single-Block Data Mover

This engine carries one data block across an SPI byte-exchange link to or from a memory card. A command sequencer elsewhere has already sent the read or write command and its address. Once that is done, a one-cycle `start` together with a direction bit and a byte length hands the data phase to this block.

For a read, the engine polls the card until the start token arrives. It then stores each payload byte into a local buffer through a simple write port, and clocks past the two trailing checksum bytes without storing them. For a write, it sends the start token, reads each payload byte from the buffer and sends it, and sends two filler bytes where the checksum would go. It then checks the card's data-response token and polls until the card is no longer busy.

Each byte goes through a request/acknowledge exchange with a separate SPI shifter. Chip select stays low for the whole data phase. Every transfer ends with chip select high and one extra filler byte, followed by a one-cycle `done`. The error and timeout flags keep their values until the next `start`.

Top module: `sd_blk_xfer`

## Requirements
- R1: After reset, and whenever no transfer is running, `cs_n` is 1 and `busy`, `done` and `xch_req` are 0.
- R2: Every byte exchanged from the first byte of a transfer up to, but not including, the closing byte is requested with `cs_n` = 0.
- R3: On a read, the engine sends 0xFF and repeats this until the received byte equals 0xFE. It then writes the next `len` received bytes to buffer addresses 0 to `len`-1, in increasing order.
- R4: After a read payload, exactly two more bytes are exchanged with 0xFF sent, and neither is written to the buffer.
- R5: On a write, the bytes sent are 0xFE, then buffer bytes 0 to `len`-1 in order, then 0xFF and 0xFF.
- R6: After a write, one more 0xFF byte is exchanged. If that received byte ANDed with 0x1F equals 0x05, the write is accepted. Any other value, for example 0x0B (checksum rejected) or 0x0D (write failed), ends the transfer with `err` = 1.
- R7: After an accepted write, 0xFF bytes are sent for as long as the received byte is 0x00. The first nonzero byte ends the polling.
- R8: Every transfer, whether it succeeds, is rejected or times out, ends with `cs_n` = 1 and one 0xFF byte. A single-cycle `done` follows, and `err` and `tmo` keep their values until the next `start`.
- R9: If the start token has not arrived within POLL_MAX polled bytes, the transfer ends with `tmo` = 1 and no buffer writes. A token that arrives in byte POLL_MAX is still accepted.
- R10: If the card is still busy after POLL_MAX busy-poll bytes, the transfer ends with `tmo` = 1.
- R11: The length `len` is taken at `start` and may be any value from 1 to MAX_LEN. Both 512 and 16 are supported.
- R12: `err` and `tmo` are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin a transfer; taken only when idle |
| is_write | input | 1 | 1 = write a block to the card, 0 = read a block from the card |
| len | input | LEN_W | Payload byte count, 1..MAX_LEN |
| busy | output | 1 | A transfer is in progress |
| done | output | 1 | One-cycle pulse when a transfer has finished |
| err | output | 1 | The card rejected the write data (valid from `done`) |
| tmo | output | 1 | The polling bound was reached (valid from `done`) |
| cs_n | output | 1 | Card chip select, active low |
| xch_req | output | 1 | One-cycle request to exchange one SPI byte |
| xch_tx | output | 8 | Byte to send; valid while `xch_req` is 1 |
| xch_done | input | 1 | One-cycle pulse: the byte exchange has finished |
| xch_rx | input | 8 | Byte received; valid while `xch_done` is 1 |
| buf_addr | output | ADDR_W | Buffer byte address |
| buf_we | output | 1 | Buffer write strobe (read transfers) |
| buf_wdata | output | 8 | Buffer write data |
| buf_rdata | input | 8 | Buffer read data at `buf_addr`, combinational |

## Verification
The embedded assertions check on every cycle that chip select is low for every payload byte, that the closing byte is 0xFF with chip select high, that the buffer is never written during a write transfer, that the poll counter stays below its bound, and that `err` and `tmo` are never both set. Only the bench's scenarios can show the rest. These are the exact byte order on the link, the payload landing at the right buffer addresses, the checksum bytes being discarded, the way each data-response token is classified, where the busy poll ends, and that a token arriving on the last allowed poll is still accepted.

// File: rtl/sd_blkx_pkg.sv
package sd_blkx_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_HUNT, ST_RDAT, ST_RCRC,
    ST_WTOK, ST_WDAT, ST_WCRC, ST_WRSP, ST_WBSY, ST_TAIL
  } xst_e;

  localparam logic [7:0] TOK_START = 8'hFE;
  localparam logic [7:0] FILL_BYTE = 8'hFF;
  localparam logic [7:0] RSP_MASK  = 8'h1F;
  localparam logic [7:0] RSP_GOOD  = 8'h05;
endpackage

// File: rtl/sd_blkx_tokdec.sv
module sd_blkx_tokdec
  import sd_blkx_pkg::*;
(
  input  logic [7:0] rx,
  output logic       is_start,
  output logic       rsp_ok,
  output logic       is_busy
);
  assign is_start = (rx == TOK_START);
  assign rsp_ok   = ((rx & RSP_MASK) == RSP_GOOD);
  assign is_busy  = (rx == 8'h00);
endmodule

// File: rtl/sd_blkx_ctr.sv
module sd_blkx_ctr #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] q
);
  logic [W-1:0] q_n;

  always_comb begin
    q_n = q;
    if (clr)      q_n = '0;
    else if (inc) q_n = q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_n;
  end

  AST_CTR_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !clr) |-> (q != {W{1'b1}})); // R11
endmodule

// File: rtl/sd_blk_xfer.sv
module sd_blk_xfer
  import sd_blkx_pkg::*;
#(
  parameter int MAX_LEN  = 512,
  parameter int POLL_MAX = 4096,
  localparam int LEN_W   = $clog2(MAX_LEN + 1),
  localparam int ADDR_W  = $clog2(MAX_LEN),
  localparam int POLL_W  = $clog2(POLL_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              is_write,
  input  logic [LEN_W-1:0]  len,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              tmo,
  output logic              cs_n,
  output logic              xch_req,
  output logic [7:0]        xch_tx,
  input  logic              xch_done,
  input  logic [7:0]        xch_rx,
  output logic [ADDR_W-1:0] buf_addr,
  output logic              buf_we,
  output logic [7:0]        buf_wdata,
  input  logic [7:0]        buf_rdata
);
  xst_e             state_q, state_n;
  logic             infl_q, infl_n;
  logic             cs_n_q, cs_n_n;
  logic             req_q, req_n;
  logic [7:0]       tx_q, tx_n;
  logic             done_q, done_n;
  logic             err_q, err_n;
  logic             tmo_q, tmo_n;
  logic             wr_q, wr_n;
  logic [LEN_W-1:0] len_q, len_n;

  logic             idx_clr, idx_inc, poll_clr, poll_inc;
  logic [LEN_W-1:0] idx;
  logic [POLL_W-1:0] poll_cnt;
  logic             rx_start, rx_rsp_ok, rx_busy;
  logic             xfer, last_pay, poll_end;

  sd_blkx_ctr #(.W(LEN_W)) u_idx (
    .clk(clk), .rst_n(rst_n), .clr(idx_clr), .inc(idx_inc), .q(idx));

  sd_blkx_ctr #(.W(POLL_W)) u_poll (
    .clk(clk), .rst_n(rst_n), .clr(poll_clr), .inc(poll_inc), .q(poll_cnt));

  sd_blkx_tokdec u_dec (
    .rx(xch_rx), .is_start(rx_start), .rsp_ok(rx_rsp_ok), .is_busy(rx_busy));

  assign xfer     = infl_q && xch_done;
  assign last_pay = (idx == len_q - LEN_W'(1));
  assign poll_end = (poll_cnt == POLL_W'(POLL_MAX - 1));

  always_comb begin
    state_n  = state_q;
    infl_n   = infl_q;
    cs_n_n   = cs_n_q;
    req_n    = 1'b0;
    tx_n     = tx_q;
    done_n   = 1'b0;
    err_n    = err_q;
    tmo_n    = tmo_q;
    wr_n     = wr_q;
    len_n    = len_q;
    idx_clr  = 1'b0;
    idx_inc  = 1'b0;
    poll_clr = 1'b0;
    poll_inc = 1'b0;

    if (state_q == ST_IDLE) begin
      if (start) begin
        state_n  = is_write ? ST_WTOK : ST_HUNT;
        cs_n_n   = 1'b0;
        err_n    = 1'b0;
        tmo_n    = 1'b0;
        wr_n     = is_write;
        len_n    = len;
        idx_clr  = 1'b1;
        poll_clr = 1'b1;
      end
    end else if (!infl_q) begin
      req_n  = 1'b1;
      infl_n = 1'b1;
      case (state_q)
        ST_WTOK: tx_n = TOK_START;
        ST_WDAT: tx_n = buf_rdata;
        default: tx_n = FILL_BYTE;
      endcase
    end else if (xfer) begin
      infl_n = 1'b0;
      case (state_q)
        ST_HUNT: begin
          if (rx_start) begin
            state_n = ST_RDAT;
            idx_clr = 1'b1;
          end else if (poll_end) begin
            tmo_n   = 1'b1;
            state_n = ST_TAIL;
            cs_n_n  = 1'b1;
          end else begin
            poll_inc = 1'b1;
          end
        end
        ST_RDAT, ST_WDAT: begin
          if (last_pay) begin
            state_n = (state_q == ST_RDAT) ? ST_RCRC : ST_WCRC;
            idx_clr = 1'b1;
          end else begin
            idx_inc = 1'b1;
          end
        end
        ST_RCRC, ST_WCRC: begin
          if (idx == LEN_W'(1)) begin
            if (state_q == ST_RCRC) begin
              state_n = ST_TAIL;
              cs_n_n  = 1'b1;
            end else begin
              state_n = ST_WRSP;
            end
          end else begin
            idx_inc = 1'b1;
          end
        end
        ST_WTOK: state_n = ST_WDAT;
        ST_WRSP: begin
          if (rx_rsp_ok) begin
            state_n  = ST_WBSY;
            poll_clr = 1'b1;
          end else begin
            err_n   = 1'b1;
            state_n = ST_TAIL;
            cs_n_n  = 1'b1;
          end
        end
        ST_WBSY: begin
          if (!rx_busy) begin
            state_n = ST_TAIL;
            cs_n_n  = 1'b1;
          end else if (poll_end) begin
            tmo_n   = 1'b1;
            state_n = ST_TAIL;
            cs_n_n  = 1'b1;
          end else begin
            poll_inc = 1'b1;
          end
        end
        ST_TAIL: begin
          state_n = ST_IDLE;
          done_n  = 1'b1;
        end
        default: state_n = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      infl_q  <= 1'b0;
      cs_n_q  <= 1'b1;
      req_q   <= 1'b0;
      tx_q    <= 8'hFF;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      tmo_q   <= 1'b0;
      wr_q    <= 1'b0;
      len_q   <= '0;
    end else begin
      state_q <= state_n;
      infl_q  <= infl_n;
      cs_n_q  <= cs_n_n;
      req_q   <= req_n;
      tx_q    <= tx_n;
      done_q  <= done_n;
      err_q   <= err_n;
      tmo_q   <= tmo_n;
      wr_q    <= wr_n;
      len_q   <= len_n;
    end
  end

  assign busy      = (state_q != ST_IDLE);
  assign done      = done_q;
  assign err       = err_q;
  assign tmo       = tmo_q;
  assign cs_n      = cs_n_q;
  assign xch_req   = req_q;
  assign xch_tx    = tx_q;
  assign buf_addr  = idx[ADDR_W-1:0];
  assign buf_we    = (state_q == ST_RDAT) && xfer;
  assign buf_wdata = xch_rx;

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (cs_n && !xch_req)); // R1
  AST_CS_LOW_PAYLOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (xch_req && (state_q == ST_RDAT || state_q == ST_WDAT)) |-> !cs_n); // R2
  AST_NO_BUF_WRITE_ON_TX: assert property (@(posedge clk) disable iff (!rst_n)
    buf_we |-> !wr_q); // R3
  AST_START_TOKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (xch_req && state_q == ST_WTOK) |-> (xch_tx == TOK_START)); // R5
  AST_TAIL_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    (xch_req && state_q == ST_TAIL) |-> (cs_n && xch_tx == FILL_BYTE)); // R8
  AST_DONE_CS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cs_n && !busy)); // R8
  AST_POLL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    poll_cnt < POLL_W'(POLL_MAX)); // R9
  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(err && tmo)); // R12
endmodule

// File: tb/tb_sd_blk_xfer.sv
module tb_sd_blk_xfer;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_LEN    = 512;
  localparam int POLL_MAX   = 8;
  localparam int LEN_W      = $clog2(MAX_LEN + 1);
  localparam int ADDR_W     = $clog2(MAX_LEN);

  logic clk, rst_n, start, is_write;
  logic [LEN_W-1:0] len;
  logic busy, done, err, tmo, cs_n, xch_req, xch_done, buf_we;
  logic [7:0] xch_tx, xch_rx, buf_wdata, buf_rdata;
  logic [ADDR_W-1:0] buf_addr;

  int n_tests = 0;
  int n_fail  = 0;

  logic [7:0] mem [MAX_LEN+1];
  logic [7:0] exp_tx[$];
  logic       exp_cs[$];
  string      exp_tag[$];
  logic [7:0] rx_q[$];
  logic [7:0] pend_rx;
  int         dly = 0;

  sd_blk_xfer #(.MAX_LEN(MAX_LEN), .POLL_MAX(POLL_MAX)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .is_write(is_write), .len(len),
    .busy(busy), .done(done), .err(err), .tmo(tmo), .cs_n(cs_n),
    .xch_req(xch_req), .xch_tx(xch_tx), .xch_done(xch_done), .xch_rx(xch_rx),
    .buf_addr(buf_addr), .buf_we(buf_we), .buf_wdata(buf_wdata),
    .buf_rdata(buf_rdata));

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  assign buf_rdata = mem[buf_addr];
  always @(posedge clk) if (buf_we) mem[buf_addr] <= buf_wdata;

  task automatic chk(input string tag, input int act, input int expv);
    n_tests++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, expv);
    end
  endtask

  task automatic push(input logic [7:0] tx, input logic cs, input logic [7:0] rx,
                      input string tag);
    exp_tx.push_back(tx);
    exp_cs.push_back(cs);
    exp_tag.push_back(tag);
    rx_q.push_back(rx);
  endtask

  // card model and scoreboard monitor
  always @(negedge clk) begin
    xch_done = 1'b0;
    if (dly > 0) begin
      dly--;
      if (dly == 0) begin
        xch_done = 1'b1;
        xch_rx   = pend_rx;
      end
    end
    if (rst_n && xch_req) begin
      if (exp_tx.size() == 0) begin
        chk("R8 unexpected extra byte", 1, 0);
        pend_rx = 8'hFF;
      end else begin
        automatic string t = exp_tag.pop_front();
        chk({t, " tx"}, xch_tx, exp_tx.pop_front());
        chk({"R2 ", t, " cs_n"}, cs_n, exp_cs.pop_front());
        pend_rx = rx_q.pop_front();
      end
      dly = 2;
    end
  end

  task automatic run(input logic wr, input int n, input logic e_err,
                     input logic e_tmo, input string tag);
    int guard;
    @(negedge clk);
    start = 1'b1; is_write = wr; len = LEN_W'(n);
    @(negedge clk);
    start = 1'b0;
    guard = 0;
    while (!done && guard < 20000) begin
      @(negedge clk);
      guard++;
    end
    chk({"R8 done seen ", tag}, done, 1);
    @(negedge clk);
    chk({"R8 done single cycle ", tag}, done, 0);
    chk({"R6 err ", tag}, err, e_err);
    chk({"R9 R10 tmo ", tag}, tmo, e_tmo);
    chk({"R12 flags ", tag}, err & tmo, 0);
    chk({"R1 idle cs_n ", tag}, cs_n, 1);
    chk({"R8 bytes left ", tag}, exp_tx.size(), 0);
    exp_tx.delete(); exp_cs.delete(); exp_tag.delete(); rx_q.delete();
    repeat (3) @(negedge clk);
    chk({"R8 flags held ", tag}, {err, tmo}, {e_err, e_tmo});
  endtask

  task automatic do_read(input int n, input int hunts, input int seed, input string tag);
    for (int i = 0; i <= MAX_LEN; i++) mem[i] = 8'h3C;
    for (int i = 0; i < hunts; i++) push(8'hFF, 1'b0, 8'hFF, {"R3 ", tag});
    push(8'hFF, 1'b0, 8'hFE, {"R3 ", tag});
    for (int i = 0; i < n; i++) push(8'hFF, 1'b0, 8'((i * 7 + seed) & 255), {"R3 ", tag});
    push(8'hFF, 1'b0, 8'hA5, {"R4 ", tag});
    push(8'hFF, 1'b0, 8'h5A, {"R4 ", tag});
    push(8'hFF, 1'b1, 8'hFF, {"R8 ", tag});
    run(1'b0, n, 1'b0, 1'b0, tag);
    for (int i = 0; i < n; i++)
      chk($sformatf("R3 R11 %s buf[%0d]", tag, i), mem[i], (i * 7 + seed) & 255);
    chk({"R4 sentinel ", tag}, mem[n], 8'h3C);
  endtask

  task automatic do_write(input int n, input logic [7:0] rsp, input int bz,
                          input logic e_err, input logic e_tmo, input string tag);
    for (int i = 0; i < n; i++) mem[i] = 8'((i * 13 + 5) & 255);
    push(8'hFE, 1'b0, 8'hFF, {"R5 ", tag});
    for (int i = 0; i < n; i++) push(mem[i], 1'b0, 8'hFF, {"R5 ", tag});
    push(8'hFF, 1'b0, 8'hFF, {"R5 ", tag});
    push(8'hFF, 1'b0, 8'hFF, {"R5 ", tag});
    push(8'hFF, 1'b0, rsp, {"R6 ", tag});
    if (!e_err) begin
      for (int i = 0; i < bz; i++) push(8'hFF, 1'b0, 8'h00, {"R7 ", tag});
      if (!e_tmo) push(8'hFF, 1'b0, 8'h3F, {"R7 ", tag});
    end
    push(8'hFF, 1'b1, 8'hFF, {"R8 ", tag});
    run(1'b1, n, e_err, e_tmo, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; is_write = 1'b0; len = '0;
    xch_done = 1'b0; xch_rx = 8'h00;
    for (int i = 0; i <= MAX_LEN; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset cs_n", cs_n, 1);
    chk("R1 reset busy", busy, 0);
    chk("R1 reset done", done, 0);
    chk("R1 reset req", xch_req, 0);

    do_read(16, 3, 11, "read16");
    do_read(512, 0, 1, "read512");
    do_read(1, POLL_MAX - 1, 77, "read_token_last_poll");

    for (int i = 0; i <= MAX_LEN; i++) mem[i] = 8'h3C;
    for (int i = 0; i < POLL_MAX; i++) push(8'hFF, 1'b0, 8'hFF, "R9 hunt");
    push(8'hFF, 1'b1, 8'hFF, "R8 hunt tail");
    run(1'b0, 16, 1'b0, 1'b1, "hunt_timeout");
    chk("R9 no buffer write", mem[0], 8'h3C);

    do_write(16, 8'hE5, 3, 1'b0, 1'b0, "write_ok");
    do_write(512, 8'h05, 0, 1'b0, 1'b0, "write512_nobusy");
    do_write(16, 8'h0B, 0, 1'b1, 1'b0, "write_crc_reject");
    do_write(16, 8'hED, 0, 1'b1, 1'b0, "write_fail_reject");
    do_write(4, 8'h25, POLL_MAX, 1'b0, 1'b1, "busy_timeout");
    do_write(4, 8'h05, POLL_MAX - 1, 1'b0, 1'b0, "busy_last_poll");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule